// File: doc/BRIEF.md
# Paired Register Operand Packer

This block sits on the processor side of a coprocessor offload path. When an instruction is handed to an external coprocessor, the block decodes the source register indices from the fixed fields of the 32-bit instruction word. It drives read addresses into a register file that has one even read port and one odd read port per operand slot. It then presents the values it reads on a register-transfer channel, together with the hart and instruction identifiers and one availability flag per register read.

Any of the first operand slots, selected by a parameter, can run in paired mode. In that mode the slot reads an even/odd register pair and packs both 32-bit values into one 64-bit operand. The pair formed by register 0 and register 1 always reads as zero, and the odd register is not read for it. Hazard tracking is outside the block. An external per-register "value available" input tells the block which operands can already be flagged.

A second parameter selects the transfer protocol:
- **Combined mode.** The transfer runs alongside issue. Flags can only accumulate until the consumer accepts the transfer with ready.
- **Split mode.** The transfer is a single-cycle pulse that is sent once every register requested at issue is available. It carries exactly the request flags and ignores ready.

Top module: `opk_operand_packer`

## Requirements
- R1: Source slot 0, 1 and 2 indices come from instruction bits [19:15], [24:20] and [31:27]. A paired slot addresses even register n (field with bit 0 cleared) on its even port and n+1 on its odd port. An unpaired slot addresses the field value directly on its even port.
- R2: A paired slot carries the even register's value in bits [31:0] and the odd register's value in bits [63:32]. An unpaired slot carries its value in bits [31:0], with any upper bits zero. The operand vector places slot s at bits [s*SLOT_W +: SLOT_W].
- R3: A paired slot whose field selects the register 0/1 pair outputs an all-zero operand. Its odd read enable stays low. Both of its flags count as available whatever the availability inputs say.
- R4: Flags for slot s start at bit s+min(s,DUAL). A paired slot owns two flags with the even half in the lower bit, and an unpaired slot owns one. The total width is NUM_SRC+DUAL. The availability input and the request input use the same layout.
- R5: DUAL=0 pairs no slot, 1 pairs slot 0, 2 pairs slots 0 and 1, and 3 pairs all three slots.
- R6: reg_id and reg_hart mirror the instruction's id and hart. In combined mode reg_valid equals inst_valid. Whenever reg_valid is low, the flags read zero.
- R7: In combined mode a flag that is set stays set on every following cycle while reg_valid stays high with the same id and hart and no handshake has occurred, even if its availability input falls.
- R8: In combined mode a transfer ends on any of the following, after which only currently available registers are flagged:
  - a cycle with reg_valid and reg_ready both high;
  - inst_valid going low;
  - a change of id or hart.
- R9: In split mode reg_valid rises in the first cycle that every requested register is available. The flags then equal the request flags, and reg_ready has no effect.
- R10: In split mode no second pulse is sent for the same id and hart while inst_valid stays high. A new id or hart, or a gap in inst_valid, re-arms the pulse.
- R11: While reset is asserted, the held flags and the split-mode sent state are cleared. With inst_valid low, reg_valid and the flags read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inst_valid | input | 1 | An offloaded instruction awaits its operands |
| inst_word | input | 32 | Instruction word |
| inst_hart | input | HART_W | Hart issuing the instruction |
| inst_id | input | ID_W | Instruction identifier |
| src_ready | input | NUM_SRC+DUAL | Per-register availability, flag layout |
| rd_req | input | NUM_SRC+DUAL | Registers requested at issue, flag layout (split mode) |
| rf_addr_even | output | NUM_SRC*5 | Even-port read address per slot |
| rf_addr_odd | output | NUM_SRC*5 | Odd-port read address per slot |
| rf_odd_en | output | NUM_SRC | Odd-port read enable per slot |
| rf_data_even | input | NUM_SRC*32 | Even-port read data per slot |
| rf_data_odd | input | NUM_SRC*32 | Odd-port read data per slot |
| reg_valid | output | 1 | Register transfer valid |
| reg_ready | input | 1 | Register transfer accepted (combined mode) |
| reg_hart | output | HART_W | Hart of the transfer |
| reg_id | output | ID_W | Id of the transfer |
| reg_ops | output | NUM_SRC*SLOT_W | Packed operand slots |
| reg_flags | output | NUM_SRC+DUAL | Per-register validity flags |

## Verification
The bench targets several specific failure modes:
- **Flag retention.** Flags must persist after their availability input drops and must be released at a handshake or on an id change. A design that forgets held flags would lose an operand, and one that never clears them would flag stale registers for the next instruction.
- **The 0/1 pair.** This pair is driven with a non-zero register 1. A design that reads x1 would leak that value into the operand and raise the odd enable.
- **Split mode.** The bench holds one id across many cycles while toggling ready. A design that fires more than once would emit a duplicate transfer, and one that honours ready would stall.
- **Layout.** Walking one-hot availability patterns expose any misplaced flag bit, and odd-numbered fields in paired slots expose a missing even alignment.

// File: rtl/opk_pkg.sv
`timescale 1ns/1ps
package opk_pkg;
   localparam int unsigned XLEN  = 32;
   localparam int unsigned IDX_W = 5;

   // first flag bit of a slot: one bit per earlier slot plus one extra per earlier pair
   function automatic int unsigned flag_base(int unsigned slot, int unsigned dual);
      return slot + ((slot < dual) ? slot : dual);
   endfunction

   // bit position of a slot's register index field in the instruction word
   function automatic int unsigned field_lsb(int unsigned slot);
      return (slot == 0) ? 15 : ((slot == 1) ? 20 : 27);
   endfunction
endpackage

// File: rtl/opk_field_decode.sv
`timescale 1ns/1ps
module opk_field_decode
   import opk_pkg::*;
#(
   parameter int unsigned NUM_SRC = 3,
   parameter int unsigned DUAL    = 2
) (
   input  logic                     inst_valid,
   input  logic [31:0]              inst_word,
   output logic [NUM_SRC*IDX_W-1:0] addr_even,
   output logic [NUM_SRC*IDX_W-1:0] addr_odd,
   output logic [NUM_SRC-1:0]       odd_en,
   output logic [NUM_SRC-1:0]       pair_zero
);
   logic unused_word;
   assign unused_word = ^inst_word;

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_slot
      localparam int unsigned LSB = field_lsb(s);
      logic [IDX_W-1:0] fld;
      assign fld = inst_word[LSB +: IDX_W];
      if (s < DUAL) begin : g_pair
         assign addr_even[s*IDX_W +: IDX_W] = {fld[IDX_W-1:1], 1'b0};
         assign addr_odd[s*IDX_W +: IDX_W]  = {fld[IDX_W-1:1], 1'b1};
         assign pair_zero[s]                = (fld[IDX_W-1:1] == '0);
         assign odd_en[s]                   = inst_valid && (fld[IDX_W-1:1] != '0);
      end else begin : g_single
         assign addr_even[s*IDX_W +: IDX_W] = fld;
         assign addr_odd[s*IDX_W +: IDX_W]  = '0;
         assign pair_zero[s]                = 1'b0;
         assign odd_en[s]                   = 1'b0;
      end
   end
endmodule

// File: rtl/opk_slot_pack.sv
`timescale 1ns/1ps
module opk_slot_pack
   import opk_pkg::*;
#(
   parameter bit          PAIRED = 1'b1,
   parameter int unsigned SLOT_W = 64,
   localparam int unsigned NH    = PAIRED ? 2 : 1
) (
   input  logic [XLEN-1:0]   even_data,
   input  logic [XLEN-1:0]   odd_data,
   input  logic              pair_zero,
   input  logic [NH-1:0]     rdy,
   output logic [SLOT_W-1:0] operand,
   output logic [NH-1:0]     avail
);
   if (PAIRED) begin : g_pair
      if (SLOT_W != 2*XLEN) begin : g_bad_width
         $error("paired slot needs a slot width of twice XLEN");
      end
      logic unused_pz;
      assign unused_pz = 1'b0;
      always_comb begin
         if (pair_zero) begin
            operand = '0;
            avail   = '1;
         end else begin
            operand = {odd_data, even_data};
            avail   = rdy;
         end
      end
   end else begin : g_single
      logic unused_single;
      assign unused_single = ^{odd_data, pair_zero};
      assign operand = SLOT_W'(even_data);
      assign avail   = rdy;
   end
endmodule

// File: rtl/opk_flag_track.sv
`timescale 1ns/1ps
module opk_flag_track #(
   parameter int unsigned FLAGS  = 5,
   parameter bit          SPLIT  = 1'b0,
   parameter int unsigned ID_W   = 4,
   parameter int unsigned HART_W = 1,
   localparam int unsigned KEY_W = ID_W + HART_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              inst_valid,
   input  logic [ID_W-1:0]   inst_id,
   input  logic [HART_W-1:0] inst_hart,
   input  logic [FLAGS-1:0]  avail,
   input  logic [FLAGS-1:0]  rd_req,
   input  logic              reg_ready,
   output logic              reg_valid,
   output logic [FLAGS-1:0]  reg_flags
);
   logic [KEY_W-1:0] key, key_q;
   logic             same_key;

   assign key      = {inst_hart, inst_id};
   assign same_key = (key == key_q);

   always_ff @(posedge clk) begin
      if (!rst_n) key_q <= '0;
      else        key_q <= key;
   end

   if (SPLIT) begin : g_split
      logic sent_q, all_ok;
      logic unused_rdy;
      assign unused_rdy = reg_ready;
      assign all_ok    = ((rd_req & ~avail) == '0);
      assign reg_valid = inst_valid && all_ok && !(sent_q && same_key);
      assign reg_flags = reg_valid ? rd_req : '0;
      always_ff @(posedge clk) begin
         if (!rst_n) sent_q <= 1'b0;
         else        sent_q <= reg_valid || (inst_valid && same_key && sent_q);
      end
   end else begin : g_combined
      logic [FLAGS-1:0] held_q, keep;
      logic unused_req;
      assign unused_req = ^rd_req;
      assign keep      = same_key ? held_q : '0;
      assign reg_valid = inst_valid;
      assign reg_flags = inst_valid ? (keep | avail) : '0;
      always_ff @(posedge clk) begin
         if (!rst_n)                       held_q <= '0;
         else if (inst_valid && !reg_ready) held_q <= reg_flags;
         else                              held_q <= '0;
      end
   end
endmodule

// File: rtl/opk_operand_packer.sv
`timescale 1ns/1ps
module opk_operand_packer
   import opk_pkg::*;
#(
   parameter int unsigned NUM_SRC = 3,
   parameter int unsigned DUAL    = 2,
   parameter bit          SPLIT   = 1'b0,
   parameter int unsigned ID_W    = 4,
   parameter int unsigned HART_W  = 1,
   localparam int unsigned FLAGS  = NUM_SRC + DUAL,
   localparam int unsigned SLOT_W = (DUAL > 0) ? 2*XLEN : XLEN
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      inst_valid,
   input  logic [31:0]               inst_word,
   input  logic [HART_W-1:0]         inst_hart,
   input  logic [ID_W-1:0]           inst_id,
   input  logic [FLAGS-1:0]          src_ready,
   input  logic [FLAGS-1:0]          rd_req,
   output logic [NUM_SRC*IDX_W-1:0]  rf_addr_even,
   output logic [NUM_SRC*IDX_W-1:0]  rf_addr_odd,
   output logic [NUM_SRC-1:0]        rf_odd_en,
   input  logic [NUM_SRC*XLEN-1:0]   rf_data_even,
   input  logic [NUM_SRC*XLEN-1:0]   rf_data_odd,
   output logic                      reg_valid,
   input  logic                      reg_ready,
   output logic [HART_W-1:0]         reg_hart,
   output logic [ID_W-1:0]           reg_id,
   output logic [NUM_SRC*SLOT_W-1:0] reg_ops,
   output logic [FLAGS-1:0]          reg_flags
);
   if (NUM_SRC < 2 || NUM_SRC > 3) begin : g_bad_nsrc
      $error("NUM_SRC must be 2 or 3");
   end
   if (DUAL > NUM_SRC) begin : g_bad_dual
      $error("DUAL may not exceed NUM_SRC");
   end
   if (ID_W < 1 || HART_W < 1) begin : g_bad_key
      $error("id and hart widths must be at least 1");
   end

   logic [NUM_SRC-1:0] pair_zero;
   logic [FLAGS-1:0]   avail_all;

   opk_field_decode #(.NUM_SRC(NUM_SRC), .DUAL(DUAL)) u_dec (
      .inst_valid (inst_valid),
      .inst_word  (inst_word),
      .addr_even  (rf_addr_even),
      .addr_odd   (rf_addr_odd),
      .odd_en     (rf_odd_en),
      .pair_zero  (pair_zero)
   );

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_slot
      localparam bit          PAIRED = (s < DUAL);
      localparam int unsigned NH     = PAIRED ? 2 : 1;
      localparam int unsigned BASE   = flag_base(s, DUAL);
      opk_slot_pack #(.PAIRED(PAIRED), .SLOT_W(SLOT_W)) u_pack (
         .even_data (rf_data_even[s*XLEN +: XLEN]),
         .odd_data  (rf_data_odd[s*XLEN +: XLEN]),
         .pair_zero (pair_zero[s]),
         .rdy       (src_ready[BASE +: NH]),
         .operand   (reg_ops[s*SLOT_W +: SLOT_W]),
         .avail     (avail_all[BASE +: NH])
      );
   end

   opk_flag_track #(
      .FLAGS(FLAGS), .SPLIT(SPLIT), .ID_W(ID_W), .HART_W(HART_W)
   ) u_trk (
      .clk        (clk),
      .rst_n      (rst_n),
      .inst_valid (inst_valid),
      .inst_id    (inst_id),
      .inst_hart  (inst_hart),
      .avail      (avail_all),
      .rd_req     (rd_req),
      .reg_ready  (reg_ready),
      .reg_valid  (reg_valid),
      .reg_flags  (reg_flags)
   );

   assign reg_id   = inst_id;
   assign reg_hart = inst_hart;
endmodule

// File: rtl/opk_checker.sv
`timescale 1ns/1ps
module opk_checker
   import opk_pkg::*;
#(
   parameter int unsigned NUM_SRC = 3,
   parameter int unsigned DUAL    = 2,
   parameter bit          SPLIT   = 1'b0,
   parameter int unsigned ID_W    = 4,
   parameter int unsigned HART_W  = 1,
   localparam int unsigned FLAGS  = NUM_SRC + DUAL,
   localparam int unsigned SLOT_W = (DUAL > 0) ? 2*XLEN : XLEN
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic [31:0]               inst_word,
   input logic [FLAGS-1:0]          rd_req,
   input logic [NUM_SRC*IDX_W-1:0]  rf_addr_even,
   input logic [NUM_SRC*IDX_W-1:0]  rf_addr_odd,
   input logic [NUM_SRC-1:0]        rf_odd_en,
   input logic                      reg_valid,
   input logic                      reg_ready,
   input logic [HART_W-1:0]         reg_hart,
   input logic [ID_W-1:0]           reg_id,
   input logic [NUM_SRC*SLOT_W-1:0] reg_ops,
   input logic [FLAGS-1:0]          reg_flags
);
   AST_FLAGS_MONOTONE: assert property (@(posedge clk) disable iff (!rst_n)
      (SPLIT == 1'b0) && $past(rst_n) && $past(reg_valid && !reg_ready) && reg_valid
      && (reg_id == $past(reg_id)) && (reg_hart == $past(reg_hart))
      |-> ((reg_flags & $past(reg_flags)) == $past(reg_flags))); // R7

   AST_IDLE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_valid |-> (reg_flags == '0)); // R6

   AST_SPLIT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (SPLIT == 1'b1) && reg_valid |-> (reg_flags == rd_req)); // R9

   AST_SPLIT_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
      (SPLIT == 1'b1) && $past(rst_n) && $past(reg_valid)
      && (reg_id == $past(reg_id)) && (reg_hart == $past(reg_hart))
      |-> !reg_valid); // R10

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_slot
      localparam int unsigned LSB = field_lsb(s);
      if (s < DUAL) begin : g_pair
         AST_ZERO_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
            reg_valid && (inst_word[LSB+1 +: IDX_W-1] == '0)
            |-> (reg_ops[s*SLOT_W +: SLOT_W] == '0) && !rf_odd_en[s]); // R3
         AST_PAIR_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
            reg_valid |-> (rf_addr_even[s*IDX_W +: IDX_W] == {inst_word[LSB+1 +: IDX_W-1], 1'b0})
            && (rf_addr_odd[s*IDX_W +: IDX_W] == (rf_addr_even[s*IDX_W +: IDX_W] | 5'd1))); // R1
      end else if (SLOT_W > XLEN) begin : g_wide_single
         AST_SINGLE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            reg_valid |-> (reg_ops[s*SLOT_W+XLEN +: SLOT_W-XLEN] == '0)); // R2
      end
   end
endmodule

bind opk_operand_packer opk_checker #(
   .NUM_SRC(NUM_SRC), .DUAL(DUAL), .SPLIT(SPLIT), .ID_W(ID_W), .HART_W(HART_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .inst_word(inst_word), .rd_req(rd_req),
   .rf_addr_even(rf_addr_even), .rf_addr_odd(rf_addr_odd), .rf_odd_en(rf_odd_en),
   .reg_valid(reg_valid), .reg_ready(reg_ready), .reg_hart(reg_hart),
   .reg_id(reg_id), .reg_ops(reg_ops), .reg_flags(reg_flags)
);

// File: tb/sim_opk_operand_packer.sv
`timescale 1ns/1ps
module sim_opk_operand_packer;
   localparam int NS = 3, DU = 2, FL = 5, SW = 64, IW = 4, HW = 1;

   logic clk = 1'b0, rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic          inst_valid = 1'b0, reg_ready = 1'b0;
   logic [31:0]   inst_word = '0;
   logic [HW-1:0] inst_hart = '0;
   logic [IW-1:0] inst_id = '0;
   logic [FL-1:0] src_ready = '0, rd_req = '0;

   logic [NS*5-1:0]  a0e, a0o, a1e, a1o;
   logic [NS-1:0]    oe0, oe1;
   logic [NS*32-1:0] d0e, d0o, d1e, d1o;
   logic             v0, v1;
   logic [HW-1:0]    h0, h1;
   logic [IW-1:0]    i0, i1;
   logic [NS*SW-1:0] ops0, ops1;
   logic [FL-1:0]    f0, f1;

   logic [31:0] regs [32];

   always_comb begin
      for (int s = 0; s < NS; s++) begin
         d0e[s*32 +: 32] = regs[a0e[s*5 +: 5]];
         d0o[s*32 +: 32] = regs[a0o[s*5 +: 5]];
         d1e[s*32 +: 32] = regs[a1e[s*5 +: 5]];
         d1o[s*32 +: 32] = regs[a1o[s*5 +: 5]];
      end
   end

   opk_operand_packer #(.NUM_SRC(NS), .DUAL(DU), .SPLIT(1'b0), .ID_W(IW), .HART_W(HW)) u0 (
      .clk(clk), .rst_n(rst_n), .inst_valid(inst_valid), .inst_word(inst_word),
      .inst_hart(inst_hart), .inst_id(inst_id), .src_ready(src_ready), .rd_req(rd_req),
      .rf_addr_even(a0e), .rf_addr_odd(a0o), .rf_odd_en(oe0),
      .rf_data_even(d0e), .rf_data_odd(d0o), .reg_valid(v0), .reg_ready(reg_ready),
      .reg_hart(h0), .reg_id(i0), .reg_ops(ops0), .reg_flags(f0));

   opk_operand_packer #(.NUM_SRC(NS), .DUAL(DU), .SPLIT(1'b1), .ID_W(IW), .HART_W(HW)) u1 (
      .clk(clk), .rst_n(rst_n), .inst_valid(inst_valid), .inst_word(inst_word),
      .inst_hart(inst_hart), .inst_id(inst_id), .src_ready(src_ready), .rd_req(rd_req),
      .rf_addr_even(a1e), .rf_addr_odd(a1o), .rf_odd_en(oe1),
      .rf_data_even(d1e), .rf_data_odd(d1o), .reg_valid(v1), .reg_ready(reg_ready),
      .reg_hart(h1), .reg_id(i1), .reg_ops(ops1), .reg_flags(f1));

   int    vectors = 0, miscompares = 0;
   bit    finished = 1'b0;
   string ph = "R11";

   // reference state
   logic [FL-1:0]   m_held = '0;
   logic [IW+HW-1:0] m_prev = '0;
   logic            m_sent = 1'b0;

   task automatic chk(input string tag, input string what, input logic [191:0] act, input logic [191:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
      end
   endtask

   function automatic logic [4:0] fld(input int s);
      int lsb;
      lsb = (s == 0) ? 15 : ((s == 1) ? 20 : 27);
      return inst_word[lsb +: 5];
   endfunction

   function automatic int fbase(input int s);
      return s + ((s < DU) ? s : DU);
   endfunction

   task automatic evaluate();
      logic [IW+HW-1:0] key;
      logic             same, allok, ev1;
      logic [FL-1:0]    zm, cur, ef0, ef1;
      logic [NS*SW-1:0] eops;
      logic [NS*5-1:0]  eaddr;
      logic [NS-1:0]    eodd;
      key  = {inst_hart, inst_id};
      same = (key == m_prev);
      zm = '0; eops = '0; eaddr = '0; eodd = '0;
      for (int s = 0; s < NS; s++) begin
         logic [4:0] f, n;
         f = fld(s);
         if (s < DU) begin
            n = {f[4:1], 1'b0};
            eaddr[s*5 +: 5] = n;
            if (n == 0) begin
               zm[fbase(s)] = 1'b1; zm[fbase(s)+1] = 1'b1;
            end else begin
               eops[s*SW +: SW] = {regs[n+5'd1], regs[n]};
               eodd[s] = inst_valid;
            end
         end else begin
            eaddr[s*5 +: 5] = f;
            eops[s*SW +: SW] = {32'h0, regs[f]};
         end
      end
      cur = src_ready | zm;
      // combined
      ef0 = inst_valid ? ((same ? m_held : '0) | cur) : '0;
      chk("R6", "u0 valid", 192'(v0), 192'(inst_valid));
      chk(ph, "u0 flags", 192'(f0), 192'(ef0));
      // split
      allok = ((rd_req & ~cur) == '0);
      ev1 = inst_valid && allok && !(m_sent && same);
      ef1 = ev1 ? rd_req : '0;
      chk("R9", "u1 valid", 192'(v1), 192'(ev1));
      chk("R9", "u1 flags", 192'(f1), 192'(ef1));
      if (inst_valid) begin
         chk("R2", "u0 operands", 192'(ops0), 192'(eops));
         chk("R2", "u1 operands", 192'(ops1), 192'(eops));
         chk("R1", "u0 even addr", 192'(a0e), 192'(eaddr));
         chk("R3", "u0 odd enable", 192'(oe0), 192'(eodd));
         chk("R6", "u0 id/hart", 192'({h0, i0}), 192'(key));
         chk("R6", "u1 id/hart", 192'({h1, i1}), 192'(key));
      end
      if (!rst_n) begin
         m_held = '0; m_sent = 1'b0; m_prev = '0;
      end else begin
         m_held = (inst_valid && !reg_ready) ? ef0 : '0;
         m_sent = ev1 || (inst_valid && same && m_sent);
         m_prev = key;
      end
   endtask

   task automatic step(input logic v, input logic [31:0] w, input logic [HW-1:0] h,
                       input logic [IW-1:0] id, input logic [FL-1:0] sr,
                       input logic [FL-1:0] rq, input logic rr);
      @(negedge clk);
      inst_valid = v; inst_word = w; inst_hart = h; inst_id = id;
      src_ready = sr; rd_req = rq; reg_ready = rr;
      #1;
      evaluate();
   endtask

   function automatic logic [31:0] mkword(input logic [4:0] r1, input logic [4:0] r2, input logic [4:0] r3);
      return {r3, 2'b00, r2, r1, 15'h0123};
   endfunction

   initial begin
      for (int r = 0; r < 32; r++) regs[r] = 32'hA000_0000 + r * 32'h0101_0011;
      regs[0] = 32'h0;
      regs[1] = 32'hDEAD_BEEF;   // must never leak through the 0/1 pair

      // R11: reset clears state, idle outputs read zero
      ph = "R11";
      for (int k = 0; k < 3; k++) step(1'b0, '0, '0, '0, '1, '1, 1'b0);
      @(negedge clk); rst_n = 1'b1;

      // R7: flags accumulate and survive a falling availability input
      ph = "R7";
      step(1'b1, mkword(5'd4, 5'd7, 5'd9), 1'b0, 4'd3, 5'b00000, 5'b00000, 1'b0);
      step(1'b1, mkword(5'd4, 5'd7, 5'd9), 1'b0, 4'd3, 5'b00001, 5'b00000, 1'b0);
      step(1'b1, mkword(5'd4, 5'd7, 5'd9), 1'b0, 4'd3, 5'b00100, 5'b00000, 1'b0);
      step(1'b1, mkword(5'd4, 5'd7, 5'd9), 1'b0, 4'd3, 5'b00000, 5'b00000, 1'b0);
      // R8: handshake ends the transfer
      ph = "R8";
      step(1'b1, mkword(5'd4, 5'd7, 5'd9), 1'b0, 4'd3, 5'b10000, 5'b00000, 1'b1);
      step(1'b1, mkword(5'd4, 5'd7, 5'd9), 1'b0, 4'd3, 5'b00000, 5'b00000, 1'b0);
      step(1'b1, mkword(5'd4, 5'd7, 5'd9), 1'b0, 4'd3, 5'b00010, 5'b00000, 1'b0);
      // R8: new id drops held flags, new hart too
      step(1'b1, mkword(5'd4, 5'd7, 5'd9), 1'b0, 4'd4, 5'b01000, 5'b00000, 1'b0);
      step(1'b1, mkword(5'd4, 5'd7, 5'd9), 1'b1, 4'd4, 5'b00000, 5'b00000, 1'b0);
      step(1'b0, mkword(5'd4, 5'd7, 5'd9), 1'b1, 4'd4, 5'b00000, 5'b00000, 1'b0);

      // R3: the 0/1 pair reads zero, flags forced, odd port idle
      ph = "R3";
      step(1'b1, mkword(5'd1, 5'd0, 5'd1), 1'b0, 4'd5, 5'b00000, 5'b01111, 1'b0);
      step(1'b1, mkword(5'd0, 5'd1, 5'd0), 1'b0, 4'd6, 5'b10000, 5'b01111, 1'b1);

      // R4 / R5: walking availability bits; slot 2 stays unpaired and reads its odd field directly
      ph = "R4";
      for (int b = 0; b < FL; b++)
         step(1'b1, mkword(5'd11, 5'd30, 5'd13), 1'b0, 4'(7 + b), 5'(1 << b), 5'b00000, 1'b1);
      ph = "R5";
      step(1'b1, mkword(5'd31, 5'd3, 5'd31), 1'b0, 4'd12, 5'b11111, 5'b00000, 1'b1);

      // R9 / R10: split pulse once all requested registers arrive, ready ignored
      ph = "R10";
      step(1'b1, mkword(5'd8, 5'd12, 5'd15), 1'b0, 4'd13, 5'b00000, 5'b10101, 1'b0);
      step(1'b1, mkword(5'd8, 5'd12, 5'd15), 1'b0, 4'd13, 5'b00101, 5'b10101, 1'b1);
      step(1'b1, mkword(5'd8, 5'd12, 5'd15), 1'b0, 4'd13, 5'b10101, 5'b10101, 1'b0);
      step(1'b1, mkword(5'd8, 5'd12, 5'd15), 1'b0, 4'd13, 5'b11111, 5'b10101, 1'b0);
      step(1'b1, mkword(5'd8, 5'd12, 5'd15), 1'b0, 4'd13, 5'b11111, 5'b10101, 1'b1);
      step(1'b1, mkword(5'd8, 5'd12, 5'd15), 1'b0, 4'd14, 5'b11111, 5'b10101, 1'b0);
      step(1'b0, mkword(5'd8, 5'd12, 5'd15), 1'b0, 4'd14, 5'b11111, 5'b10101, 1'b0);
      step(1'b1, mkword(5'd8, 5'd12, 5'd15), 1'b0, 4'd14, 5'b11111, 5'b10101, 1'b0);

      // R8: long mixed run
      ph = "R8";
      begin
         logic [IW-1:0] id;
         logic [HW-1:0] h;
         logic [31:0]   w;
         logic [FL-1:0] rq;
         id = 4'd0; h = 1'b0; w = $urandom(17); rq = '0;
         for (int k = 0; k < 3000; k++) begin
            if ($urandom_range(7) == 0) begin
               id = id + 4'($urandom_range(3) + 1);
               w = $urandom; rq = FL'($urandom);
               if ($urandom_range(3) == 0) h = ~h;
            end
            if ($urandom_range(15) == 0) regs[$urandom_range(31)] = $urandom;
            step($urandom_range(7) != 0, w, h, id, FL'($urandom), rq, $urandom_range(3) == 0);
         end
      end

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      #150000;
      if (!finished) begin
         miscompares++;
         $display("FAIL watchdog: actual still running, expected done");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end
endmodule